// File: doc/BRIEF.md
# Elastic Channel Buffer with Selectable Transparency

This block sits on a single valid/ready channel between a producer and a consumer and holds a parameterised number of tokens. A token moves across either side of the block only in a cycle where that side's valid and ready are both high. The data width, the number of slots and a transparency flag are all parameters. Tokens leave in the order they arrived.

With transparency off, the block acts as a register slice with a FIFO behind it. Output valid and output data come straight from flops, so any loop of combinational logic through the channel is broken. A token entering an empty buffer appears at the output exactly one cycle later. Input ready follows output ready, so a full buffer that is being drained still accepts a new token in the same cycle.

With transparency on, the block adds no latency. An empty buffer whose consumer is ready passes the input token to the output in the same cycle and does not store it. Tokens pile up in the slots only while the consumer stalls, so a slow consumer does not stall the producer until every slot is taken. In this mode input ready comes from a flop and depends only on how many tokens are stored.

Top module: `elastic_buf`

## Requirements
- R1: After reset the buffer is empty: out_valid is 0 and in_ready is 1.
- R2: With transparency off, a token accepted into an empty buffer is not visible in the cycle it is accepted. It appears on out_valid and out_data in the next cycle.
- R3: With transparency on and the buffer empty, an input token is shown on out_valid and out_data in the same cycle. If out_ready is 1, the token is consumed without being stored, and out_valid is 0 in the next cycle once in_valid drops.
- R4: Tokens leave in the order they were accepted. No token is lost or duplicated under any pattern of in_valid and out_ready.
- R5: The buffer holds exactly SLOTS tokens while the consumer stalls. Once SLOTS tokens are stored, in_ready is 0.
- R6: With transparency off, in_ready is 0 only when all slots are full and out_ready is 0. A full buffer with out_ready at 1 keeps in_ready at 1.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged in the next cycle.
- R8: With transparency on, in_ready depends only on the stored count. A full buffer keeps in_ready at 0 in a cycle where out_ready rises.
- R9: With out_ready held at 1 and in_valid held at 1, the buffer accepts one token per cycle in both modes. The output trails the input by one cycle with transparency off and by zero cycles with transparency on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Producer offers a token |
| in_ready | output | 1 | Buffer can take a token this cycle |
| in_data | input | DATA_W | Token payload from the producer |
| out_valid | output | 1 | Buffer offers a token |
| out_ready | input | 1 | Consumer takes the offered token this cycle |
| out_data | output | DATA_W | Token payload to the consumer |

## Verification
The embedded properties check the following on every cycle:
- The slot counter never overflows or underflows.
- A stalled output keeps its valid and data.
- With transparency on, an input token shows at the output at once.
- With transparency off, a token entering an empty buffer shows one cycle later.

Only the bench scenarios can show the rest:
- Exact capacity per mode.
- The different ready behaviour of the two modes when full.
- Full-rate streaming with the right output offset.
- End-to-end ordering of long random valid/ready streams, checked against a queue model.

// File: rtl/eb_pkg.sv
package eb_pkg;

  // Pointer width for a ring of the given depth (at least one bit).
  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Next ring index with wrap at depth.
  function automatic int wrap_next(input int cur, input int depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/eb_slot_store.sv
module eb_slot_store #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slot_arr [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = wr_en && (wr_idx == PTR_W'(i));

    // Payload storage carries no reset; valid tracking lives in the occupancy unit.
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q <= wr_data;
      end
    end

    assign slot_arr[i] = slot_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rd_idx == PTR_W'(i)) begin
        rd_data = slot_arr[i];
      end
    end
  end

endmodule

// File: rtl/eb_occupancy.sv
module eb_occupancy #(
  parameter int SLOTS = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             empty,
  output logic             full
);

  localparam int               CNT_W   = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOTS);

  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty_q, empty_d;
  logic             full_q, full_d;
  logic             upd_en;

  assign upd_en = push || pop;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d = PTR_W'(eb_pkg::wrap_next(int'(wr_q), SLOTS));
    end
    if (pop) begin
      rd_d = PTR_W'(eb_pkg::wrap_next(int'(rd_q), SLOTS));
    end
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
    empty_d = (cnt_d == '0);
    full_d  = (cnt_d == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else if (upd_en) begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      cnt_q   <= cnt_d;
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign empty  = empty_q;
  assign full   = full_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q < CNT_MAX)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R4

endmodule

// File: rtl/elastic_buf.sv
module elastic_buf #(
  parameter int DATA_W      = 16,
  parameter int SLOTS       = 4,
  parameter bit TRANSPARENT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam int PTR_W = eb_pkg::ptr_width(SLOTS);

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              empty, full;
  logic              push, pop;
  logic [DATA_W-1:0] rd_data;

  eb_occupancy #(
    .SLOTS (SLOTS),
    .PTR_W (PTR_W)
  ) u_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .empty  (empty),
    .full   (full)
  );

  eb_slot_store #(
    .DATA_W (DATA_W),
    .SLOTS  (SLOTS),
    .PTR_W  (PTR_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (push),
    .wr_idx  (wr_ptr),
    .wr_data (in_data),
    .rd_idx  (rd_ptr),
    .rd_data (rd_data)
  );

  if (TRANSPARENT) begin : g_pass
    logic bypass;

    // Empty and drained: the token flows around the slots.
    assign bypass    = empty && out_ready;
    assign out_valid = !empty || in_valid;
    assign out_data  = empty ? in_data : rd_data;
    assign in_ready  = !full;
    assign push      = in_valid && !full && !bypass;
    assign pop       = !empty && out_ready;

    AST_PASS_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> out_valid); // R3
    AST_READY_FROM_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && out_ready) |=> in_ready); // R8
  end else begin : g_reg
    assign out_valid = !empty;
    assign out_data  = rd_data;
    assign in_ready  = !full || out_ready;
    assign push      = in_valid && in_ready;
    assign pop       = !empty && out_ready;

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !out_valid) |=> out_valid); // R2
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

endmodule

// File: tb/test_elastic_buf.sv
module test_elastic_buf;

  localparam int W = 16;

  logic                clk;
  logic                rst_n;
  logic [1:0]          in_valid;
  logic [1:0]          in_ready;
  logic [1:0]          out_valid;
  logic [1:0]          out_ready;
  logic [1:0][W-1:0]   in_data;
  logic [1:0][W-1:0]   out_data;

  int n_chk  = 0;
  int n_fail = 0;

  // Index 0: registered mode, 2 slots. Index 1: transparent mode, 4 slots.
  elastic_buf #(.DATA_W(W), .SLOTS(2), .TRANSPARENT(1'b0)) i_elastic_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid[0]), .in_ready(in_ready[0]), .in_data(in_data[0]),
    .out_valid(out_valid[0]), .out_ready(out_ready[0]), .out_data(out_data[0])
  );

  elastic_buf #(.DATA_W(W), .SLOTS(4), .TRANSPARENT(1'b1)) i_elastic_buf_tr (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid[1]), .in_ready(in_ready[1]), .in_data(in_data[1]),
    .out_valid(out_valid[1]), .out_ready(out_ready[1]), .out_data(out_data[1])
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int slots_of(input int idx);
    return (idx == 0) ? 2 : 4;
  endfunction

  task automatic t_reset();
    rst_n     = 1'b0;
    in_valid  = '0;
    out_ready = '0;
    in_data   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int i = 0; i < 2; i++) begin
      chk(out_valid[i] == 1'b0, "R1", "out_valid after reset", 32'(out_valid[i]), 0);
      chk(in_ready[i] == 1'b1, "R1", "in_ready after reset", 32'(in_ready[i]), 1);
    end
  endtask

  task automatic t_reg_latency();
    @(negedge clk);
    out_ready[0] = 1'b1;
    in_valid[0]  = 1'b1;
    in_data[0]   = 16'h5A5A;
    #1;
    chk(out_valid[0] == 1'b0, "R2", "valid in accept cycle", 32'(out_valid[0]), 0);
    @(negedge clk);
    in_valid[0] = 1'b0;
    #1;
    chk(out_valid[0] && out_data[0] == 16'h5A5A, "R2", "token one cycle later",
        32'(out_data[0]), 32'h5A5A);
    @(negedge clk);
    #1;
    chk(out_valid[0] == 1'b0, "R2", "empty after drain", 32'(out_valid[0]), 0);
    out_ready[0] = 1'b0;
  endtask

  task automatic t_pass_through();
    @(negedge clk);
    out_ready[1] = 1'b1;
    in_valid[1]  = 1'b1;
    in_data[1]   = 16'hC3C3;
    #1;
    chk(out_valid[1] && out_data[1] == 16'hC3C3, "R3", "same-cycle pass",
        32'(out_data[1]), 32'hC3C3);
    @(negedge clk);
    in_valid[1] = 1'b0;
    #1;
    chk(out_valid[1] == 1'b0, "R3", "bypassed token not stored", 32'(out_valid[1]), 0);
    out_ready[1] = 1'b0;
  endtask

  task automatic t_capacity(input int idx);
    int acc = 0;
    out_ready[idx] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      in_valid[idx] = 1'b1;
      in_data[idx]  = W'(16'h0100 + acc);
      #1;
      if (!in_ready[idx]) break;
      acc++;
    end
    chk(acc == slots_of(idx), "R5", "tokens held while stalled", 32'(acc), 32'(slots_of(idx)));
    in_valid[idx]  = 1'b0;
    out_ready[idx] = 1'b1;
    #1;
    if (idx == 0)
      chk(in_ready[0] == 1'b1, "R6", "full but draining keeps ready", 32'(in_ready[0]), 1);
    else
      chk(in_ready[1] == 1'b0, "R8", "ready ignores out_ready when full", 32'(in_ready[1]), 0);
    chk(out_valid[idx] && out_data[idx] == 16'h0100, "R4", "first drained token",
        32'(out_data[idx]), 32'h0100);
    for (int k = 1; k < slots_of(idx); k++) begin
      @(negedge clk);
      #1;
      chk(out_valid[idx] && out_data[idx] == W'(16'h0100 + k), "R4", "drain order",
          32'(out_data[idx]), 32'(16'h0100 + k));
    end
    @(negedge clk);
    #1;
    chk(out_valid[idx] == 1'b0, "R4", "no extra token", 32'(out_valid[idx]), 0);
    out_ready[idx] = 1'b0;
  endtask

  task automatic t_stall_hold(input int idx);
    out_ready[idx] = 1'b0;
    @(negedge clk);
    in_valid[idx] = 1'b1;
    in_data[idx]  = 16'h1111;
    @(negedge clk);
    in_data[idx]  = 16'h2222;
    #1;
    chk(out_valid[idx] && out_data[idx] == 16'h1111, "R7", "head shown under stall",
        32'(out_data[idx]), 32'h1111);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid[idx] = 1'b0;
      #1;
      chk(out_valid[idx] && out_data[idx] == 16'h1111, "R7", "head held under stall",
          32'(out_data[idx]), 32'h1111);
    end
    @(negedge clk);
    out_ready[idx] = 1'b1;
    #1;
    chk(out_valid[idx] && out_data[idx] == 16'h1111, "R4", "first after stall",
        32'(out_data[idx]), 32'h1111);
    @(negedge clk);
    #1;
    chk(out_valid[idx] && out_data[idx] == 16'h2222, "R4", "second after stall",
        32'(out_data[idx]), 32'h2222);
    @(negedge clk);
    #1;
    chk(out_valid[idx] == 1'b0, "R4", "empty after stall drain", 32'(out_valid[idx]), 0);
    out_ready[idx] = 1'b0;
  endtask

  task automatic t_stream(input int idx);
    out_ready[idx] = 1'b1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      in_valid[idx] = 1'b1;
      in_data[idx]  = W'(16'hA000 + k);
      #1;
      chk(in_ready[idx] == 1'b1, "R9", "ready while streaming", 32'(in_ready[idx]), 1);
      if (idx == 1)
        chk(out_valid[1] && out_data[1] == W'(16'hA000 + k), "R9", "zero-offset stream",
            32'(out_data[1]), 32'(16'hA000 + k));
      else if (k == 0)
        chk(out_valid[0] == 1'b0, "R2", "stream start hidden", 32'(out_valid[0]), 0);
      else
        chk(out_valid[0] && out_data[0] == W'(16'hA000 + k - 1), "R9", "one-offset stream",
            32'(out_data[0]), 32'(16'hA000 + k - 1));
    end
    @(negedge clk);
    in_valid[idx] = 1'b0;
    #1;
    if (idx == 0)
      chk(out_valid[0] && out_data[0] == 16'hA00F, "R9", "last streamed token",
          32'(out_data[0]), 32'hA00F);
    @(negedge clk);
    #1;
    chk(out_valid[idx] == 1'b0, "R9", "empty after stream", 32'(out_valid[idx]), 0);
    out_ready[idx] = 1'b0;
  endtask

  task automatic t_random(input int idx, input int cycles);
    logic [W-1:0] q[$];
    logic [W-1:0] nxt = W'(16'h4000);
    bit           pend = 1'b0;
    int           errs = 0;
    int           seen = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (!pend && ($urandom % 3 != 0)) begin
        in_data[idx] = nxt;
        nxt++;
        pend = 1'b1;
      end
      in_valid[idx]  = pend;
      out_ready[idx] = ($urandom % 2) == 1;
      #1;
      if (in_valid[idx] && in_ready[idx]) begin
        q.push_back(in_data[idx]);
        pend = 1'b0;
      end
      if (out_valid[idx] && out_ready[idx]) begin
        seen++;
        if (q.size() == 0) begin
          errs++;
          chk(1'b0, "R4", "token from nowhere", 32'(out_data[idx]), 0);
        end else begin
          if (out_data[idx] != q[0]) begin
            errs++;
            chk(1'b0, "R4", "random order", 32'(out_data[idx]), 32'(q[0]));
          end
          void'(q.pop_front());
        end
      end
    end
    @(negedge clk);
    in_valid[idx]  = 1'b0;
    out_ready[idx] = 1'b1;
    for (int c = 0; c < 10 && q.size() > 0; c++) begin
      #1;
      if (out_valid[idx]) begin
        seen++;
        if (out_data[idx] != q[0]) begin
          errs++;
          chk(1'b0, "R4", "drain order", 32'(out_data[idx]), 32'(q[0]));
        end
        void'(q.pop_front());
      end
      @(negedge clk);
    end
    #1;
    chk(q.size() == 0 && out_valid[idx] == 1'b0, "R4", "all tokens delivered once",
        32'(q.size()), 0);
    chk(errs == 0 && seen > 100, "R4", "random stream clean", 32'(errs), 0);
    out_ready[idx] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_reg_latency();
    t_pass_through();
    for (int i = 0; i < 2; i++) begin
      t_capacity(i);
      t_stall_hold(i);
      t_stream(i);
      t_random(i, 3000);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule